// File: doc/BRIEF.md
# Debounced Push-Button Event Counter

This block counts presses of a mechanical push button and holds the total in an eight-bit register. A raw contact does not switch cleanly. When pressed or released, it chatters between high and low for a while. Counting every rising edge of such a signal would add several to the total for a single press. This block first cleans the button level and then counts only the rising edges of the cleaned level.

There are two cleaning schemes, chosen by a mode input. The first is a set/reset hold register driven by two complementary buttons. A "make" button sets it and a "break" button clears it, so chatter on one contact cannot undo the state. The second uses one button. A level from it is accepted only after the synchronized input has stayed unchanged for a parameterised number of clock cycles (500000 by default). All raw buttons first pass through a two-flop synchronizer. A direction input selects counting up or down. The count wraps modulo 256 both ways.

Mode and direction are treated as static while presses are being counted. They are applied directly, without synchronization.

Top module: `btn_event_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `tally` becomes 0. In the same edge the stability filter loads its recorded sample and its clean level from the synchronized single-button input, and clears its stable-cycle count.
- R2: Every raw button input passes through two synchronizing flops. In hold-register mode, a `btn_make` rise that arrives before clock edge k changes `tally` at edge k+3. It does not change `tally` earlier.
- R3: The hold register (`src_sel`=1) sets when the synchronized `btn_make` is high and `btn_break` is low. It clears when `btn_break` is high and `btn_make` is low. It keeps its value when both are high or both are low. It resets to 0.
- R4: In the stability filter (`src_sel`=0), the stable-cycle count restarts at zero on any cycle where the synchronized input differs from the recorded sample. On that cycle the recorded sample takes the new input.
- R5: The filter's clean level takes the recorded sample only once the stable-cycle count has reached `HOLD_CYCLES`. A pulse shorter than that leaves the clean level, and therefore `tally`, unchanged.
- R6: `tally` changes by exactly one on each 0-to-1 transition of the selected clean level, one cycle after the transition. A falling transition or a steady level leaves it unchanged.
- R7: With `cnt_down`=0 each counted edge adds one. With `cnt_down`=1 each counted edge subtracts one.
- R8: The count wraps modulo 256. Incrementing 255 gives 0, and decrementing 0 gives 255.
- R9: `src_sel`=1 selects the hold register and `src_sel`=0 selects the stability filter. Activity on the inputs of the unselected scheme leaves `tally` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_single | input | 1 | Raw button for the stability filter |
| btn_make | input | 1 | Raw button that sets the hold register |
| btn_break | input | 1 | Raw button that clears the hold register |
| src_sel | input | 1 | 1 selects the hold register, 0 the stability filter |
| cnt_down | input | 1 | 1 counts down, 0 counts up |
| tally | output | 8 | Press count |

## Verification
The hold-register path is driven with presses whose make and break contacts each chatter several times. This separates one count per press from one count per chatter edge. The path is also given an overlap in which both contacts are held together, which shows whether the register holds or takes a side. The stability filter gets chattering presses that are followed by holds longer than the threshold, plus isolated pulses shorter than the threshold. The two kinds of stimulus show whether the filter accepts sustained levels and whether it rejects brief ones. Long runs of presses in each direction cross 255/0 to expose wrap errors. Toggling the unused scheme's buttons shows whether the mode multiplexer leaks.

// File: rtl/btn_cnt_pkg.sv
package btn_cnt_pkg;

  typedef enum logic {
    SRC_FILTER = 1'b0,
    SRC_HOLD   = 1'b1
  } src_e;

  // A rising edge seen by comparing a level with its registered copy.
  function automatic logic level_rose(input logic now_lvl, input logic was_lvl);
    return now_lvl & ~was_lvl;
  endfunction

  // Next state of a make/break hold register; both-high or both-low holds.
  function automatic logic hold_next(input logic cur, input logic mk, input logic brk);
    logic nxt;
    nxt = cur;
    if (mk && !brk)
      nxt = 1'b1;
    else if (brk && !mk)
      nxt = 1'b0;
    return nxt;
  endfunction

endpackage

// File: rtl/bc_sync.sv
module bc_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

  // R2: output follows the input after exactly STAGES edges (checked on the 2-stage default)
  if (STAGES == 2) begin : g_chk
    a_r2_two_flop_delay: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(rst, 2) |-> sync_out == $past(async_in, 2))
      else $error("R2: synchronizer delay broken");
  end

endmodule

// File: rtl/bc_hold_clean.sv
module bc_hold_clean (
  input  logic clk,
  input  logic rst,
  input  logic make_s,
  input  logic break_s,
  output logic level
);
  import btn_cnt_pkg::*;

  logic hold_q;
  logic set_evt;
  logic clr_evt;

  assign set_evt = make_s & ~break_s;
  assign clr_evt = break_s & ~make_s;

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= hold_next(hold_q, make_s, break_s);
  end

  assign level = hold_q;

  a_r3_sets: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> level)
    else $error("R3: hold register failed to set");

  a_r3_clears: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> !level)
    else $error("R3: hold register failed to clear");

  a_r3_holds: assert property (@(posedge clk) disable iff (rst)
    !set_evt && !clr_evt |=> $stable(level))
    else $error("R3: hold register moved without a one-sided request");

endmodule

// File: rtl/bc_stable_filter.sv
module bc_stable_filter #(
  parameter int HOLD_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LIM = HW'(HOLD_CYCLES);

  logic          rec_q;
  logic          clean_q;
  logic [HW-1:0] run_q;
  logic          mismatch;
  logic          run_done;

  assign mismatch = (din != rec_q);
  assign run_done = (run_q == HOLD_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q   <= din;
      clean_q <= din;
      run_q   <= '0;
    end else if (mismatch) begin
      rec_q <= din;
      run_q <= '0;
    end else if (run_done) begin
      clean_q <= rec_q;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level = clean_q;

  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> run_q == '0 && rec_q == $past(din) && clean_q == $past(din))
    else $error("R1: filter reset load wrong");

  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> run_q == '0)
    else $error("R4: stable count did not restart");

  a_r5_only_after_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$stable(clean_q) |-> $past(run_q) == HOLD_LIM)
    else $error("R5: clean level moved before hold time");

  a_r5_no_overrun: assert property (@(posedge clk) disable iff (rst)
    run_q <= HOLD_LIM)
    else $error("R5: stable count overran");

endmodule

// File: rtl/bc_edge_tally.sv
module bc_edge_tally #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level,
  input  logic             down,
  output logic [CNT_W-1:0] tally
);
  import btn_cnt_pkg::*;

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise_evt;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur, input logic dn);
    return dn ? cur - 1'b1 : cur + 1'b1;
  endfunction

  assign rise_evt = level_rose(level, prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= level;
      cnt_q  <= '0;
    end else begin
      prev_q <= level;
      if (rise_evt) cnt_q <= step(cnt_q, down);
    end
  end

  assign tally = cnt_q;

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> tally == '0)
    else $error("R1: tally not cleared by reset");

  a_r6_only_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && tally != $past(tally) |-> $past(rise_evt))
    else $error("R6: tally moved without a rising edge");

  a_r7_r8_up: assert property (@(posedge clk) disable iff (rst)
    rise_evt && !down |=> tally == CNT_W'($past(tally) + 1'b1))
    else $error("R7/R8: increment wrong");

  a_r7_r8_down: assert property (@(posedge clk) disable iff (rst)
    rise_evt && down |=> tally == CNT_W'($past(tally) - 1'b1))
    else $error("R7/R8: decrement wrong");

endmodule

// File: rtl/btn_event_counter.sv
module btn_event_counter #(
  parameter int CNT_W       = 8,
  parameter int HOLD_CYCLES = 500000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_single,
  input  logic             btn_make,
  input  logic             btn_break,
  input  logic             src_sel,
  input  logic             cnt_down,
  output logic [CNT_W-1:0] tally
);
  import btn_cnt_pkg::*;

  localparam int NBTN = 3;

  logic [NBTN-1:0] raw_vec;
  logic [NBTN-1:0] sync_vec;
  logic            hold_lvl;
  logic            filt_lvl;
  logic            sel_lvl;
  src_e            src;

  assign raw_vec = {btn_single, btn_make, btn_break};
  assign src     = src_e'(src_sel);

  bc_sync #(.WIDTH(NBTN), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw_vec),
    .sync_out (sync_vec)
  );

  bc_hold_clean u_hold (
    .clk     (clk),
    .rst     (rst),
    .make_s  (sync_vec[1]),
    .break_s (sync_vec[0]),
    .level   (hold_lvl)
  );

  bc_stable_filter #(.HOLD_CYCLES(HOLD_CYCLES)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .din   (sync_vec[2]),
    .level (filt_lvl)
  );

  assign sel_lvl = (src == SRC_HOLD) ? hold_lvl : filt_lvl;

  bc_edge_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst   (rst),
    .level (sel_lvl),
    .down  (cnt_down),
    .tally (tally)
  );

  // R9: with the source held, a steady selected level keeps tally still
  a_r9_selected_only: assert property (@(posedge clk) disable iff (rst)
    $stable(src_sel) && $stable(sel_lvl) |=> $stable(tally))
    else $error("R9: tally moved while the selected level was steady");

endmodule

// File: tb/btn_event_counter_tb_top.sv
module btn_event_counter_tb_top;

  localparam int HOLD = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btn_single = 1'b0;
  logic       btn_make = 1'b0;
  logic       btn_break = 1'b0;
  logic       src_sel = 1'b1;
  logic       cnt_down = 1'b0;
  logic [7:0] tally;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  btn_event_counter #(.CNT_W(8), .HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .btn_single(btn_single), .btn_make(btn_make),
    .btn_break(btn_break), .src_sel(src_sel), .cnt_down(cnt_down), .tally(tally)
  );

  // Behavioural reference: a queue gives the two-edge input delay, integers hold the rest.
  logic [2:0] pipe[$];
  int m_rec, m_clean, m_run, m_hold, m_prev, m_cnt;

  initial begin
    pipe = '{3'b000, 3'b000};
    m_rec = 0; m_clean = 0; m_run = 0; m_hold = 0; m_prev = 0; m_cnt = 0;
  end

  always @(posedge clk) begin
    logic [2:0] seen;
    int lvl, n_rec, n_clean, n_run, n_hold, n_prev, n_cnt;
    seen = pipe[0];
    lvl  = src_sel ? m_hold : m_clean;
    n_rec = m_rec; n_clean = m_clean; n_run = m_run;
    n_hold = m_hold; n_cnt = m_cnt; n_prev = lvl;
    if (rst) begin
      n_rec = seen[2]; n_clean = seen[2]; n_run = 0; n_hold = 0; n_cnt = 0;
      pipe = '{3'b000, 3'b000};
    end else begin
      if (int'(seen[2]) != m_rec) begin n_rec = seen[2]; n_run = 0; end
      else if (m_run == HOLD) n_clean = m_rec;
      else n_run = m_run + 1;
      if (seen[1] && !seen[0]) n_hold = 1;
      else if (seen[0] && !seen[1]) n_hold = 0;
      if (lvl == 1 && m_prev == 0) n_cnt = cnt_down ? (m_cnt + 255) % 256 : (m_cnt + 1) % 256;
      void'(pipe.pop_front());
      pipe.push_back({btn_single, btn_make, btn_break});
    end
    m_rec = n_rec; m_clean = n_clean; m_run = n_run;
    m_hold = n_hold; m_prev = n_prev; m_cnt = n_cnt;
  end

  always @(negedge clk) begin
    cyc++;
    n_vec++;
    if (int'(tally) != m_cnt) begin
      n_bad++;
      $display("FAIL %s cycle %0d: tally=%0d expected %0d", cur_req, cyc, tally, m_cnt);
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: tally=%0d expected run to finish", tally);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: tally=%0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; btn_single = 0; btn_make = 0; btn_break = 0;
    tick(3);
    rst = 1'b0;
    tick(2);
  endtask

  // Make contact chatters, settles, then break contact chatters, settles.
  task automatic hold_press(input int bounces);
    for (int i = 0; i < bounces; i++) begin btn_make = 1; tick(1); btn_make = 0; tick(1); end
    btn_make = 1; tick(4); btn_make = 0; tick(2);
    for (int i = 0; i < bounces; i++) begin btn_break = 1; tick(1); btn_break = 0; tick(1); end
    btn_break = 1; tick(4); btn_break = 0; tick(2);
  endtask

  task automatic filt_press(input int bounces);
    for (int i = 0; i < bounces; i++) begin btn_single = 1; tick(1); btn_single = 0; tick(2); end
    btn_single = 1; tick(HOLD + 8);
    for (int i = 0; i < bounces; i++) begin btn_single = 0; tick(2); btn_single = 1; tick(1); end
    btn_single = 0; tick(HOLD + 8);
  endtask

  initial begin
    // R1: reset clears tally
    cur_req = "R1";
    src_sel = 1; cnt_down = 0;
    do_reset();
    check("R1", tally, 0);

    // R2: latency of three edges after the edge that samples the make press
    cur_req = "R2";
    btn_make = 1;
    tick(3);
    check("R2 early", tally, 0);
    tick(1);
    check("R2 on time", tally, 1);
    btn_make = 0; btn_break = 1; tick(5); btn_break = 0; tick(3);

    // R3/R6: chattering presses in hold mode, one count each
    cur_req = "R3";
    for (int p = 0; p < 5; p++) hold_press(p + 1);
    check("R3 R6 chattering presses", tally, 6);

    // R3: both contacts held keeps the register set; break alone clears it
    btn_make = 1; tick(4); btn_break = 1; tick(6);
    check("R3 overlap counted once", tally, 7);
    btn_make = 0; tick(6); btn_break = 0; tick(3);
    btn_make = 1; tick(6); btn_make = 0; tick(3);
    check("R3 cleared then set again", tally, 8);
    btn_break = 1; tick(5); btn_break = 0; tick(3);

    // R9: single-button activity ignored in hold mode
    cur_req = "R9";
    for (int i = 0; i < 3; i++) begin btn_single = 1; tick(HOLD + 5); btn_single = 0; tick(HOLD + 5); end
    check("R9 hold mode ignores btn_single", tally, 8);

    // R5/R6: filter mode presses
    cur_req = "R5";
    src_sel = 0;
    do_reset();
    for (int p = 0; p < 4; p++) filt_press(p + 2);
    check("R5 R6 filtered presses", tally, 4);

    // R4/R5: short pulses and interrupted runs rejected
    cur_req = "R4";
    for (int w = 1; w <= HOLD; w++) begin btn_single = 1; tick(w); btn_single = 0; tick(HOLD + 4); end
    check("R4 R5 short pulses ignored", tally, 4);
    for (int i = 0; i < 4; i++) begin btn_single = 1; tick(HOLD - 2); btn_single = 0; tick(1); end
    tick(HOLD + 4);
    check("R4 interrupted runs ignored", tally, 4);

    // R9: make/break activity ignored in filter mode
    cur_req = "R9";
    for (int i = 0; i < 3; i++) hold_press(2);
    check("R9 filter mode ignores make/break", tally, 4);

    // R7/R8: down count from zero wraps
    cur_req = "R7";
    src_sel = 1; cnt_down = 1;
    do_reset();
    hold_press(2);
    check("R7 R8 0 minus 1", tally, 255);
    hold_press(1); hold_press(3);
    check("R7 down by two", tally, 253);

    // R8: up count through 255
    cur_req = "R8";
    cnt_down = 0;
    do_reset();
    for (int p = 0; p < 256; p++) hold_press(0);
    check("R8 256 presses wrap to 0", tally, 0);
    hold_press(1);
    check("R8 after wrap", tally, 1);

    tick(2);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule